// File: doc/BRIEF.md
# Banked GPIO Controller with Masked-Write Aliases

This block is a register-mapped general-purpose I/O controller. Pins are grouped into banks. Each bank has four ports, and each port is eight pins wide. Every port holds four writable byte registers and one read-only byte:

- a mode-select byte that puts a pin into GPIO mode,
- a drive-enable byte,
- a drive-value byte,
- an interrupt-enable byte that is stored only and has no effect on the pads,
- a read-only byte with the synchronised pin levels.

The block sits on a plain 32-bit register bus. The bus has an address, a write strobe, write data and registered read data. The block drives a pad output vector and a pad output-enable vector.

Software can flip single pins without a read-modify-write sequence. It does this through a second copy of the mode, drive-enable and drive-value registers, placed at a fixed alias offset. On that copy, the upper byte of the write data selects which bits change, and the lower byte gives their new values. Interrupt logic, edge detection and pin muxing are left to other blocks.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every mode, drive-enable, drive-value and interrupt-enable bit is 0. `pad_oe` and `pad_out` are all 0, and reads of those registers return 0.
- R2: Pin number p maps as follows: bit p[2:0] within port p[4:3] of bank p/32. That pin sits at bit (p mod 8) of byte port (p/8). A register's address is bank×BANK_STRIDE + port×4 + group offset. The group offsets are mode 0x00, drive-enable 0x10, drive-value 0x20, input 0x30 and interrupt-enable 0x50.
- R3: A write to a direct register replaces all 8 bits with `bus_wdata[7:0]`. A read returns the byte in `bus_rdata[7:0]`, with bits [31:8] zero. The read data appears one clock after the address is presented.
- R4: The alias registers sit at MASK_OFFSET + bank×BANK_STRIDE + port×4 + group offset, for the mode (0x00), drive-enable (0x10) and drive-value (0x20) groups only. On a write, bit i of the target takes `bus_wdata[i]` when `bus_wdata[8+i]` is 1 and keeps its value otherwise. A write whose mask byte is zero changes nothing.
- R5: A read of an alias register returns the current byte of the register it shadows in bits [7:0], with zeros above.
- R6: `pad_oe` for a pin is 1 exactly when both its mode bit and its drive-enable bit are 1. `pad_out` follows the drive-value bit. Neither output changes in a cycle that follows no bus write.
- R7: A change on `pad_in` passes through two synchronising flops before the input register shows it. A read that is held on the input register shows the new level three clock edges after the change, and the old level one and two edges after.
- R8: The following writes change no state: writes to the input register, to group offsets 0x40 and 0x60 and above, to the input or interrupt group of the alias copy, to unaligned addresses, and to banks at or beyond NUM_BANKS. Reads of any such address return 0.
- R9: The interrupt-enable bytes can be written and read back, and they never affect `pad_oe` or `pad_out`.
- R10: The drive-value register reads back exactly what was written, whatever the pad input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data; bits [15:8] are the mask on alias writes |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | NUM_BANKS×32 | Asynchronous pin levels |
| pad_out | output | NUM_BANKS×32 | Level driven on each pin |
| pad_oe | output | NUM_BANKS×32 | Drive enable for each pin |

## Verification
Some properties are checked by assertions on every cycle. The pads hold steady when no write occurs. A write that decodes to nothing, to the input group or to interrupt-enable leaves the pads untouched, and so does an alias write with an empty mask. The pads are quiet right after reset. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model of every byte. These include the merge of mask and value bits, the mapping of pin numbers onto banks, ports and bits, readback through both the direct and alias copies, the three-edge latency of the input path, and reads of unmapped addresses returning zero.

// File: rtl/gpio_ctrl_pkg.sv
// Package: shared types and helpers for the banked GPIO controller.
// Assumes ports are 8 bits wide and four ports make one bank.
package gpio_ctrl_pkg;

    localparam int PORT_BITS      = 8;
    localparam int PORTS_PER_BANK = 4;
    localparam int BUS_W          = 32;

    // Register group selected by an address.
    typedef enum logic [2:0] {
        GRP_CFG  = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_IE   = 3'd4,
        GRP_NONE = 3'd7
    } gpio_grp_e;

    // New byte after a write: full replace, or a bitwise merge under mask.
    function automatic logic [PORT_BITS-1:0] merge_byte(
        input logic [PORT_BITS-1:0]   old_v,
        input logic                   use_mask,
        input logic [2*PORT_BITS-1:0] wd
    );
        if (use_mask)
            return (old_v & ~wd[2*PORT_BITS-1:PORT_BITS]) |
                   (wd[PORT_BITS-1:0] & wd[2*PORT_BITS-1:PORT_BITS]);
        return wd[PORT_BITS-1:0];
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Turns a byte address into a hit flag, an alias flag, a register group and a
// port index. Assumes BANK_STRIDE is a power of two and at least 0x80. Direct
// decoding wins over alias decoding when both could match.
module gpio_addr_decode
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_BANKS   = 8,
    parameter int BANK_STRIDE = 256,
    parameter int MASK_OFFSET = 128,
    parameter int PORT_IDX_W  = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic                  masked,
    output gpio_grp_e             grp,
    output logic [PORT_IDX_W-1:0] port_idx
);

    localparam int                STRIDE_LG = $clog2(BANK_STRIDE);
    localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'(BANK_STRIDE - 1);
    localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(MASK_OFFSET);
    localparam logic [ADDR_W-1:0] BANK_LIM  = ADDR_W'(NUM_BANKS);

    // Classify an offset inside a bank; alias copies expose only three groups.
    function automatic gpio_grp_e group_of(input logic [ADDR_W-1:0] offs,
                                           input logic alias_sel);
        logic [ADDR_W-1:0] g;
        g = offs >> 4;
        if (offs[1:0] != 2'b00)                  return GRP_NONE;
        if (g == ADDR_W'(0))                     return GRP_CFG;
        if (g == ADDR_W'(1))                     return GRP_OE;
        if (g == ADDR_W'(2))                     return GRP_OUT;
        if (!alias_sel && (g == ADDR_W'(3)))     return GRP_IN;
        if (!alias_sel && (g == ADDR_W'(5)))     return GRP_IE;
        return GRP_NONE;
    endfunction

    logic [ADDR_W-1:0] d_bank, d_offs, m_rel, m_bank, m_offs;
    gpio_grp_e         d_grp, m_grp;

    // Split the address both ways and choose the matching interpretation.
    always_comb begin
        d_bank   = addr >> STRIDE_LG;
        d_offs   = addr & OFFS_MASK;
        d_grp    = group_of(d_offs, 1'b0);
        m_rel    = addr - MASK_BASE;
        m_bank   = m_rel >> STRIDE_LG;
        m_offs   = m_rel & OFFS_MASK;
        m_grp    = (addr >= MASK_BASE) ? group_of(m_offs, 1'b1) : GRP_NONE;
        hit      = 1'b0;
        masked   = 1'b0;
        grp      = GRP_NONE;
        port_idx = '0;
        if ((d_grp != GRP_NONE) && (d_bank < BANK_LIM)) begin
            hit      = 1'b1;
            grp      = d_grp;
            port_idx = {d_bank[PORT_IDX_W-3:0], d_offs[3:2]};
        end else if ((m_grp != GRP_NONE) && (m_bank < BANK_LIM)) begin
            hit      = 1'b1;
            masked   = 1'b1;
            grp      = m_grp;
            port_idx = {m_bank[PORT_IDX_W-3:0], m_offs[3:2]};
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs
// Holds the mode, drive-enable, drive-value and interrupt-enable bytes of
// every port. A write hits at most one port and one group. Assumes the
// decoder never flags the input group or an alias interrupt-enable as a hit
// with a mask.
module gpio_port_regs
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PORTS  = 32,
    parameter int PORT_IDX_W = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_masked,
    input  gpio_grp_e                           wr_grp,
    input  logic [PORT_IDX_W-1:0]               wr_port,
    input  logic [2*PORT_BITS-1:0]              wr_data,
    output logic [NUM_PORTS-1:0][PORT_BITS-1:0] cfg_q,
    output logic [NUM_PORTS-1:0][PORT_BITS-1:0] oe_q,
    output logic [NUM_PORTS-1:0][PORT_BITS-1:0] out_q,
    output logic [NUM_PORTS-1:0][PORT_BITS-1:0] ie_q
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic                 sel;
        logic [PORT_BITS-1:0] cfg_r, oe_r, out_r, ie_r;

        assign sel = wr_en && (wr_port == PORT_IDX_W'(p));

        // Update this port's selected byte on a write; clear all on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
                oe_r  <= '0;
                out_r <= '0;
                ie_r  <= '0;
            end else if (sel) begin
                case (wr_grp)
                    GRP_CFG: cfg_r <= merge_byte(cfg_r, wr_masked, wr_data);
                    GRP_OE:  oe_r  <= merge_byte(oe_r,  wr_masked, wr_data);
                    GRP_OUT: out_r <= merge_byte(out_r, wr_masked, wr_data);
                    GRP_IE:  ie_r  <= merge_byte(ie_r,  wr_masked, wr_data);
                    default: ;
                endcase
            end
        end

        assign cfg_q[p] = cfg_r;
        assign oe_q[p]  = oe_r;
        assign out_q[p] = out_r;
        assign ie_q[p]  = ie_r;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchroniser for the asynchronous pin levels. Assumes each pin is
// independent, so no bus coherence is needed across pins.
module gpio_in_sync #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Shift the pin levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl (top)
// Banked GPIO controller. Each port has direct registers and masked-write
// alias registers. Pads drive when mode and drive-enable are both set. Read
// data is registered, one cycle after the address. Assumes one access per
// cycle and a word-aligned bus.
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int BANK_STRIDE = 256,
    parameter int MASK_OFFSET = 128,
    parameter int ADDR_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [NUM_BANKS*32-1:0]   pad_in,
    output logic [NUM_BANKS*32-1:0]   pad_out,
    output logic [NUM_BANKS*32-1:0]   pad_oe
);

    localparam int NUM_PORTS  = NUM_BANKS * PORTS_PER_BANK;
    localparam int NUM_PINS   = NUM_PORTS * PORT_BITS;
    localparam int PORT_IDX_W = $clog2(NUM_PORTS);

    logic                                dec_hit;
    logic                                dec_masked;
    gpio_grp_e                           dec_grp;
    logic [PORT_IDX_W-1:0]               dec_port;
    logic [NUM_PORTS-1:0][PORT_BITS-1:0] cfg_q, oe_q, out_q, ie_q, in_q;
    logic [NUM_PINS-1:0]                 in_sync;
    logic [PORT_BITS-1:0]                rd_byte;
    logic                                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:2*PORT_BITS];

    gpio_addr_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_BANKS   (NUM_BANKS),
        .BANK_STRIDE (BANK_STRIDE),
        .MASK_OFFSET (MASK_OFFSET),
        .PORT_IDX_W  (PORT_IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .masked   (dec_masked),
        .grp      (dec_grp),
        .port_idx (dec_port)
    );

    gpio_port_regs #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_IDX_W (PORT_IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we && dec_hit),
        .wr_masked (dec_masked),
        .wr_grp    (dec_grp),
        .wr_port   (dec_port),
        .wr_data   (bus_wdata[2*PORT_BITS-1:0]),
        .cfg_q     (cfg_q),
        .oe_q      (oe_q),
        .out_q     (out_q),
        .ie_q      (ie_q)
    );

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    assign in_q = in_sync;

    // Pick the byte addressed this cycle; unmapped addresses give zero.
    always_comb begin
        rd_byte = '0;
        if (dec_hit) begin
            case (dec_grp)
                GRP_CFG: rd_byte = cfg_q[dec_port];
                GRP_OE:  rd_byte = oe_q[dec_port];
                GRP_OUT: rd_byte = out_q[dec_port];
                GRP_IN:  rd_byte = in_q[dec_port];
                GRP_IE:  rd_byte = ie_q[dec_port];
                default: rd_byte = '0;
            endcase
        end
    end

    // Register the read data, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= {{(BUS_W-PORT_BITS){1'b0}}, rd_byte};
    end

    assign pad_oe  = cfg_q & oe_q;
    assign pad_out = out_q;

endmodule

// File: rtl/gpio_ctrl_checker.sv
// Module: gpio_ctrl_checker
// Assertions on the pad outputs against bus writes, bound into the top.
module gpio_ctrl_checker
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic                dec_hit,
    input logic                dec_masked,
    input gpio_grp_e           dec_grp,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);

    // R1: pads are quiet in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // R6: without a bus write the pads hold.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> ($stable(pad_oe) && $stable(pad_out)));

    // R8: unmapped or input-group writes leave the pads untouched.
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (!dec_hit || dec_grp == GRP_IN))
        |-> ($stable(pad_oe) && $stable(pad_out)));

    // R4: an alias write with an empty mask changes nothing.
    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && dec_hit && dec_masked && bus_wdata[15:8] == 8'h00)
        |-> ($stable(pad_oe) && $stable(pad_out)));

    // R9: interrupt-enable writes never reach the pads.
    p_ie_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && dec_hit && dec_grp == GRP_IE)
        |-> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_bank_ctrl gpio_ctrl_checker #(
    .NUM_PINS (NUM_PINS)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .dec_hit    (dec_hit),
    .dec_masked (dec_masked),
    .dec_grp    (dec_grp),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/gpio_bank_ctrl_bench.sv
// Bench for gpio_bank_ctrl: directed corner cases plus seeded random traffic,
// checked against a byte-level model of every port.
module gpio_bank_ctrl_bench;

    localparam int NB     = 8;
    localparam int STRIDE = 'h100;
    localparam int MOFF   = 'h80;
    localparam int AW     = 12;
    localparam int NPORT  = NB * 4;
    localparam int NPIN   = NPORT * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: kind 0 mode, 1 drive-enable, 2 drive-value, 3 interrupt-enable
    logic [7:0] mdl [4][NPORT];
    int         goff [4] = '{'h00, 'h10, 'h20, 'h50};

    always #5 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [AW-1:0] reg_addr(int port, int off, bit alias_sel);
        return AW'((alias_sel ? MOFF : 0) + (port / 4) * STRIDE + off + (port % 4) * 4);
    endfunction

    function automatic logic [7:0] apply(logic [7:0] old_v, bit alias_sel, logic [15:0] wd);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (alias_sel && !wd[8+i]) ? old_v[i] : wd[i];
        return r;
    endfunction

    task automatic chk(string req, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk);
        #1 d = bus_rdata;
    endtask

    // Write through the model and the design, then compare the pads.
    task automatic mwr(int port, int kind, bit alias_sel, logic [15:0] d, string req);
        wr(reg_addr(port, goff[kind], alias_sel), {16'h0, d});
        mdl[kind][port] = apply(mdl[kind][port], alias_sel, d);
        chk_pads(req);
    endtask

    task automatic chk_pads(string req);
        logic [NPIN-1:0] eo, ev;
        for (int p = 0; p < NPIN; p++) begin
            eo[p] = mdl[0][p/8][p%8] & mdl[1][p/8][p%8];
            ev[p] = mdl[2][p/8][p%8];
        end
        chk({req, " pad_oe"}, pad_oe, eo);
        chk({req, " pad_out"}, pad_out, ev);
    endtask

    task automatic chk_reg(int port, int kind, bit alias_sel, string req);
        logic [31:0] d;
        rd(reg_addr(port, goff[kind], alias_sel), d);
        chk(req, NPIN'(d), NPIN'({24'h0, mdl[kind][port]}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  old_b;
        void'($urandom(32'h5eed_0042));
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < NPORT; p++) mdl[k][p] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values everywhere
        chk_pads("R1");
        for (int p = 0; p < NPORT; p++)
            for (int k = 0; k < 4; k++) chk_reg(p, k, 1'b0, "R1");

        // R2: pin 37 -> bank 1, port 0, bit 5; pin 250 -> bank 7, port 3, bit 2
        wr(12'h100, 32'h20); wr(12'h110, 32'h20); wr(12'h120, 32'h20);
        mdl[0][4] = 8'h20; mdl[1][4] = 8'h20; mdl[2][4] = 8'h20;
        chk("R2 pin37 oe", NPIN'(pad_oe[37]), NPIN'(1));
        chk("R2 pin37 out", NPIN'(pad_out[37]), NPIN'(1));
        wr(12'h70C, 32'h04); wr(12'h71C, 32'h04);
        mdl[0][31] = 8'h04; mdl[1][31] = 8'h04;
        chk("R2 pin250 oe", NPIN'(pad_oe[250]), NPIN'(1));
        chk_pads("R2");

        // R3: direct write replaces all bits, read is zero-extended
        mwr(9, 2, 1'b0, 16'hFF_3C, "R3");
        mwr(9, 2, 1'b0, 16'h00_C1, "R3");
        rd(reg_addr(9, 'h20, 1'b0), d);
        chk("R3 readback", NPIN'(d), NPIN'(32'h0000_00C1));

        // R4: alias merge and empty mask
        mwr(10, 2, 1'b0, 16'h00_5A, "R4");
        mwr(10, 2, 1'b1, 16'h0F_A5, "R4");
        chk_reg(10, 2, 1'b0, "R4 merged");
        mwr(10, 0, 1'b1, 16'h00_FF, "R4 empty mask");
        chk_reg(10, 0, 1'b0, "R4 empty mask");
        mwr(10, 1, 1'b1, 16'h80_80, "R4 single bit");
        mwr(10, 0, 1'b1, 16'h81_FF, "R4 single bit");

        // R5: alias reads match the direct copy
        for (int k = 0; k < 3; k++) chk_reg(10, k, 1'b1, "R5");

        // R7: synchroniser latency on port 13
        @(negedge clk);
        pad_in = {NPIN{1'b0}};
        bus_addr = reg_addr(13, 'h30, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        pad_in[13*8 +: 8] = 8'h96;
        @(posedge clk); #1 chk("R7 edge1", NPIN'(bus_rdata), NPIN'(0));
        @(posedge clk); #1 chk("R7 edge2", NPIN'(bus_rdata), NPIN'(0));
        @(posedge clk); #1 chk("R7 edge3", NPIN'(bus_rdata), NPIN'(32'h96));

        // R8: ignored writes and zero reads
        old_b = 8'h96;
        wr(reg_addr(13, 'h30, 1'b0), 32'h0000_FF00);
        rd(reg_addr(13, 'h30, 1'b0), d);
        chk("R8 input write", NPIN'(d), NPIN'({24'h0, old_b}));
        wr(12'h040, 32'hFFFF); wr(12'h064, 32'hFFFF); wr(12'h0B0, 32'hFFFF);
        wr(12'h0D0, 32'hFFFF); wr(12'h001, 32'hFFFF); wr(12'h800, 32'hFFFF);
        chk_pads("R8");
        for (int p = 0; p < NPORT; p++)
            for (int k = 0; k < 4; k++) chk_reg(p, k, 1'b0, "R8 state");
        rd(12'h040, d); chk("R8 read 0x040", NPIN'(d), NPIN'(0));
        rd(12'h0B0, d); chk("R8 read 0x0B0", NPIN'(d), NPIN'(0));
        rd(12'h800, d); chk("R8 read 0x800", NPIN'(d), NPIN'(0));
        rd(12'h002, d); chk("R8 read unaligned", NPIN'(d), NPIN'(0));

        // R9: interrupt-enable storage only
        mwr(4, 3, 1'b0, 16'h00_FF, "R9");
        chk_reg(4, 3, 1'b0, "R9 readback");

        // R10: drive-value readback against opposite pad level
        pad_in = {NPIN{1'b1}};
        mwr(20, 2, 1'b0, 16'h00_00, "R10");
        repeat (3) @(posedge clk);
        chk_reg(20, 2, 1'b0, "R10");

        // random traffic over all ports and groups
        for (int n = 0; n < 600; n++) begin
            int port, kind;
            bit alias_sel;
            port      = int'($urandom_range(NPORT - 1));
            kind      = int'($urandom_range(3));
            alias_sel = (kind != 3) && $urandom_range(1) == 1;
            mwr(port, kind, alias_sel, 16'($urandom), alias_sel ? "R4 random" : "R3 random");
            if (n % 4 == 0)
                chk_reg(int'($urandom_range(NPORT - 1)), int'($urandom_range(3)),
                        1'b0, "R3 random read");
            if (n % 7 == 0)
                chk_reg(int'($urandom_range(NPORT - 1)), int'($urandom_range(2)),
                        1'b1, "R5 random read");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule